// File: doc/BRIEF.md
# NAND Flash ECC Access Sequencer

This block is the register-driven control front end of a NAND flash port whose error correction can run as either a Hamming or a Reed-Solomon code. A host writes a small register set over a simple single-cycle bus. From that register set the block drives the flash select, command-latch and address-latch lines. It also holds the ECC generator enable and reset, a Reed-Solomon mode bit, an encode/decode bit, a selector between the payload area and the spare (check-byte) area, and a start command for the error-locator calculation.

Each host access to the data register becomes one flash byte cycle. The same byte goes to an external ECC engine, together with a flag that marks it as payload or as stored check bytes. The Hamming and Reed-Solomon arithmetic sits outside the block, behind that engine port.

After the last stored check byte of a decode pass has been read, the block holds a fixed lockout window. During that window flash accesses and calculation starts are refused and a sticky violation flag is raised.

Top module: `nand_ecc_seq`

## Requirements
- R1: Flash select `flash_ce` equals control-register bits [3:2], `flash_cle` equals bit 4 and `flash_ale` equals bit 5 (control register at bus address 0). They follow the register in either code mode.
- R2: Writing 1 to control bit 1 requests an ECC reset. The request produces a one-cycle `eng_clr` pulse on the following cycle only if the enable (control bit 0) was already 1 before that write. Otherwise it is ignored. Bit 1 always reads back 0.
- R3: A write to the data register (address 2) produces a `flash_we` strobe, with `flash_dout` equal to the written byte, only while the write-allow bit (control bit 6) is 1.
- R4: With the Reed-Solomon bit (mode register address 1, bit 0) at 0, the spare-select bit (control bit 7) and the decode bit (mode bit 1) are forced to 0. Writes of 1 to them read back 0, and `eng_is_chk` and `eng_decode` stay 0.
- R5: Every performed data-register read (`flash_re`, read data = `flash_din`) or write (`flash_we`) forwards its byte on `eng_byte` with `eng_valid` = 1 when the enable bit is 1, and with `eng_valid` = 0 when it is 0. `eng_is_chk` equals the spare-select bit.
- R6: In Reed-Solomon decode mode with spare select 1, the CHK_BYTES-th check-byte read (default 4) sets `busy` (status register address 3, bit 0) to 1 from the next cycle for exactly LOCK_CYC cycles (default 20).
- R7: While `busy` is 1, data-register reads and writes and calculation starts are refused (no `flash_re`, `flash_we` or `eng_go`). Each refused request sets the sticky violation flag (status bit 1). Writing 1 to status bit 1 clears it.
- R8: While the burst bit (mode bit 3) is 1, a control write that would change the spare-select bit leaves it unchanged. The other control bits still update.
- R9: Writing 1 to mode bit 2, with the Reed-Solomon bit already 1 and written as 1, and `busy` at 0, gives a single-cycle `eng_go` pulse on the next cycle. `eng_done` sets the done flag (status bit 2). A launch clears the flag, but a same-cycle `eng_done` wins.
- R10: After reset all registers read 0, all flash and engine outputs are 0, and the mode bit 2 position reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 mode, 2 data, 3 status |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational) |
| flash_ce | output | 2 | Flash chip selects |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_we | output | 1 | Flash write strobe |
| flash_re | output | 1 | Flash read strobe |
| flash_dout | output | 8 | Byte to flash |
| flash_din | input | 8 | Byte from flash |
| eng_en | output | 1 | ECC generator enable |
| eng_clr | output | 1 | ECC generator reset pulse |
| eng_valid | output | 1 | Byte forwarded to engine |
| eng_byte | output | 8 | Forwarded byte |
| eng_is_chk | output | 1 | Forwarded byte is a stored check byte |
| eng_decode | output | 1 | Engine in decode mode |
| eng_go | output | 1 | Start error-locator calculation |
| eng_done | input | 1 | Engine calculation complete |
| busy | output | 1 | Post-check-read lockout active |

## Verification
Two things can land on the done flag in the same cycle: a calculation launch, which clears the flag, and the engine's completion pulse, which sets it. The bench holds `eng_done` high across the very cycle in which it writes the start bit, then reads the status register. It expects `eng_go` pulsed and the done flag still 1. A separate launch without completion must clear the flag.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_MODE = 2'd1;
   localparam logic [1:0] ADR_DATA = 2'd2;
   localparam logic [1:0] ADR_STAT = 2'd3;

   // control register, bit 7 down to bit 0
   typedef struct packed {
      logic       spare;
      logic       wr_allow;
      logic       ale;
      logic       cle;
      logic [1:0] ce;
      logic       rst;
      logic       en;
   } ctrl_t;

   // stored mode bits (start bit is a pulse, not stored)
   typedef struct packed {
      logic burst;
      logic decode;
      logic rs;
   } mode_t;

endpackage

// File: rtl/nand_ecc_regs.sv
module nand_ecc_regs
   import nand_ecc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          busy,
   input  logic          acc_refused,
   input  logic          eng_done,
   output ctrl_t         ctrl,
   output mode_t         mode,
   output logic          clr_q,
   output logic          go_q,
   output logic          viol,
   output logic          done
);

   logic [7:0] wd;
   logic       wr_ctrl, wr_mode, wr_stat;
   logic       go_req, go_ok, go_refused;
   logic       spare_next;

   assign wd      = bus_wdata[7:0];
   assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
   assign wr_mode = bus_wr && (bus_addr == ADR_MODE);
   assign wr_stat = bus_wr && (bus_addr == ADR_STAT);

   assign go_req     = wr_mode && wd[2] && wd[0] && mode.rs;
   assign go_ok      = go_req && !busy;
   assign go_refused = go_req && busy;

   // a spare-select change is refused while a burst is open
   always_comb begin
      if (mode.burst && (wd[7] != ctrl.spare)) spare_next = ctrl.spare;
      else                                     spare_next = mode.rs & wd[7];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= '0;
         mode  <= '0;
         clr_q <= 1'b0;
         go_q  <= 1'b0;
         viol  <= 1'b0;
         done  <= 1'b0;
      end else begin
         clr_q <= wr_ctrl && wd[1] && ctrl.en;
         go_q  <= go_ok;
         if (wr_ctrl) begin
            ctrl.en       <= wd[0];
            ctrl.rst      <= 1'b0;
            ctrl.ce       <= wd[3:2];
            ctrl.cle      <= wd[4];
            ctrl.ale      <= wd[5];
            ctrl.wr_allow <= wd[6];
            ctrl.spare    <= spare_next;
         end
         if (wr_mode) begin
            mode.rs     <= wd[0];
            mode.decode <= wd[0] & wd[1];
            mode.burst  <= wd[3];
            if (!wd[0]) ctrl.spare <= 1'b0;
         end
         if (acc_refused || go_refused) viol <= 1'b1;
         else if (wr_stat && wd[1])     viol <= 1'b0;
         if (eng_done)   done <= 1'b1;
         else if (go_ok) done <= 1'b0;
      end
   end

endmodule

// File: rtl/nand_ecc_lock.sv
module nand_ecc_lock #(
   parameter int LOCK_CYC  = 20,
   parameter int CHK_BYTES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chk_rd,
   input  logic spare,
   input  logic sync_clr,
   output logic busy
);

   localparam int LW = $clog2(LOCK_CYC + 1);

   logic [LW-1:0] lock_cnt;
   logic          last_byte;

   if (LOCK_CYC < 1)  begin : g_bad_lock  $error("LOCK_CYC must be at least 1");  end
   if (CHK_BYTES < 1) begin : g_bad_chk   $error("CHK_BYTES must be at least 1"); end

   if (CHK_BYTES == 1) begin : g_single
      assign last_byte = chk_rd;
   end else begin : g_count
      localparam int CW = $clog2(CHK_BYTES);
      localparam logic [CW-1:0] LAST = CW'(CHK_BYTES - 1);
      logic [CW-1:0] n_q, base;
      logic          spare_d;

      assign base      = (sync_clr || (spare != spare_d)) ? '0 : n_q;
      assign last_byte = chk_rd && (base == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            n_q     <= '0;
            spare_d <= 1'b0;
         end else begin
            spare_d <= spare;
            if (chk_rd) n_q <= (base == LAST) ? '0 : base + 1'b1;
            else        n_q <= base;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lock_cnt <= '0;
      else if (last_byte)      lock_cnt <= LW'(LOCK_CYC);
      else if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
   end

   assign busy = (lock_cnt != '0);

endmodule

// File: rtl/nand_ecc_xfer.sv
module nand_ecc_xfer
   import nand_ecc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic [7:0]    flash_din,
   input  ctrl_t         ctrl,
   input  mode_t         mode,
   input  logic          busy,
   output logic          flash_we,
   output logic          flash_re,
   output logic [7:0]    flash_dout,
   output logic          eng_valid,
   output logic [7:0]    eng_byte,
   output logic          eng_is_chk,
   output logic          acc_refused,
   output logic          chk_rd
);

   logic data_rd, data_wr;

   assign data_rd     = bus_rd && (bus_addr == ADR_DATA);
   assign data_wr     = bus_wr && (bus_addr == ADR_DATA);
   assign flash_re    = data_rd && !busy;
   assign flash_we    = data_wr && ctrl.wr_allow && !busy;
   assign flash_dout  = bus_wdata[7:0];
   assign acc_refused = busy && (data_rd || data_wr);
   assign eng_valid   = ctrl.en && (flash_re || flash_we);
   assign eng_byte    = flash_re ? flash_din : bus_wdata[7:0];
   assign eng_is_chk  = ctrl.spare;
   assign chk_rd      = flash_re && mode.rs && mode.decode && ctrl.spare;

endmodule

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
   import nand_ecc_pkg::*;
#(
   parameter int DW        = 8,
   parameter int LOCK_CYC  = 20,
   parameter int CHK_BYTES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic [1:0]    flash_ce,
   output logic          flash_cle,
   output logic          flash_ale,
   output logic          flash_we,
   output logic          flash_re,
   output logic [7:0]    flash_dout,
   input  logic [7:0]    flash_din,
   output logic          eng_en,
   output logic          eng_clr,
   output logic          eng_valid,
   output logic [7:0]    eng_byte,
   output logic          eng_is_chk,
   output logic          eng_decode,
   output logic          eng_go,
   input  logic          eng_done,
   output logic          busy
);

   if (DW < 8) begin : g_bad_dw $error("DW must be at least 8"); end

   ctrl_t ctrl;
   mode_t mode;
   logic  viol, done, acc_refused, chk_rd;
   logic  rs_q, wr_allow_q;
   logic [7:0] rd_byte;

   nand_ecc_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .busy(busy), .acc_refused(acc_refused),
      .eng_done(eng_done), .ctrl(ctrl), .mode(mode), .clr_q(eng_clr),
      .go_q(eng_go), .viol(viol), .done(done)
   );

   nand_ecc_xfer #(.DW(DW)) u_xfer (
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .flash_din(flash_din), .ctrl(ctrl), .mode(mode),
      .busy(busy), .flash_we(flash_we), .flash_re(flash_re),
      .flash_dout(flash_dout), .eng_valid(eng_valid), .eng_byte(eng_byte),
      .eng_is_chk(eng_is_chk), .acc_refused(acc_refused), .chk_rd(chk_rd)
   );

   nand_ecc_lock #(.LOCK_CYC(LOCK_CYC), .CHK_BYTES(CHK_BYTES)) u_lock (
      .clk(clk), .rst_n(rst_n), .chk_rd(chk_rd), .spare(ctrl.spare),
      .sync_clr(eng_clr), .busy(busy)
   );

   assign flash_ce   = ctrl.ce;
   assign flash_cle  = ctrl.cle;
   assign flash_ale  = ctrl.ale;
   assign eng_en     = ctrl.en;
   assign eng_decode = mode.decode;
   assign rs_q       = mode.rs;
   assign wr_allow_q = ctrl.wr_allow;

   always_comb begin
      unique case (bus_addr)
         ADR_CTRL: rd_byte = ctrl;
         ADR_MODE: rd_byte = {4'b0, mode.burst, 1'b0, mode.decode, mode.rs};
         ADR_DATA: rd_byte = flash_din;
         default:  rd_byte = {5'b0, done, viol, busy};
      endcase
   end

   assign bus_rdata = DW'(rd_byte);

endmodule

// File: rtl/nand_ecc_seq_chk.sv
module nand_ecc_seq_chk #(
   parameter int LOCK_CYC = 20
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic flash_we,
   input logic flash_re,
   input logic eng_clr,
   input logic eng_en,
   input logic eng_go,
   input logic eng_is_chk,
   input logic eng_decode,
   input logic rs_q,
   input logic wr_allow_q
);

   localparam int RW = $clog2(LOCK_CYC + 2);
   logic [RW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 1'b1;
      else           run <= '0;
   end

   // R2: a reset pulse needs the enable that was set before the request
   a_r2_clr_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      eng_clr |-> $past(eng_en));

   // R3: write strobes only under write-allow
   a_r3_we_allowed: assert property (@(posedge clk) disable iff (!rst_n)
      flash_we |-> wr_allow_q);

   // R4: Hamming mode keeps check qualifier and decode low
   a_r4_hamming_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_q |-> (!eng_is_chk && !eng_decode));

   // R6: lockout window never exceeds its length
   a_r6_lock_len: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run < RW'(LOCK_CYC)));

   // R7: no flash strobe during lockout
   a_r7_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(flash_we || flash_re));

   // R9: a launch only happens in Reed-Solomon mode
   a_r9_go_rs: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |-> rs_q);

endmodule

bind nand_ecc_seq nand_ecc_seq_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .flash_we(flash_we),
   .flash_re(flash_re), .eng_clr(eng_clr), .eng_en(eng_en), .eng_go(eng_go),
   .eng_is_chk(eng_is_chk), .eng_decode(eng_decode), .rs_q(rs_q),
   .wr_allow_q(wr_allow_q)
);

// File: tb/nand_ecc_seq_bench.sv
module nand_ecc_seq_bench;

   localparam int CLK_P = 10;
   localparam int DW    = 8;
   localparam int NV    = 20;
   // [11:10] 0 write / 1 read-compare, [9:8] address, [7:0] data
   localparam logic [11:0] VEC [NV] = '{
      {2'd0, 2'd0, 8'h3C}, {2'd1, 2'd0, 8'h3C},
      {2'd0, 2'd0, 8'h80}, {2'd1, 2'd0, 8'h00},
      {2'd0, 2'd1, 8'h03}, {2'd1, 2'd1, 8'h03},
      {2'd0, 2'd1, 8'h06}, {2'd1, 2'd1, 8'h00},
      {2'd1, 2'd3, 8'h00},
      {2'd0, 2'd1, 8'h01}, {2'd0, 2'd0, 8'h80}, {2'd1, 2'd0, 8'h80},
      {2'd0, 2'd1, 8'h09}, {2'd0, 2'd0, 8'h00}, {2'd1, 2'd0, 8'h80},
      {2'd0, 2'd1, 8'h01}, {2'd0, 2'd0, 8'h00}, {2'd1, 2'd0, 8'h00},
      {2'd0, 2'd0, 8'h02}, {2'd1, 2'd0, 8'h00}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0, bus_rdata;
   logic [1:0] flash_ce;
   logic flash_cle, flash_ale, flash_we, flash_re;
   logic [7:0] flash_dout, flash_din = '0;
   logic eng_en, eng_clr, eng_valid, eng_is_chk, eng_decode, eng_go, busy;
   logic eng_done = 1'b0;
   logic [7:0] eng_byte;

   int n_cmp = 0, n_bad = 0;
   logic fin = 1'b0;
   logic [7:0] v;
   logic p_we, p_re, p_valid, p_chk;
   logic [7:0] p_byte, p_dout;

   always #(CLK_P/2) clk = ~clk;

   nand_ecc_seq #(.DW(DW)) u_nand_ecc_seq (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic probe();
      p_we = flash_we; p_re = flash_re; p_valid = eng_valid;
      p_chk = eng_is_chk; p_byte = eng_byte; p_dout = flash_dout;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #1 probe();
      @(posedge clk); #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata[7:0]; probe();
      @(posedge clk); #1 bus_rd = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk); #1;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!fin) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 2 + 1) rst_n = 1'b1;
      idle();
      // R10 reset state
      rd(2'd3, v); chk("R10 status after reset", v, 8'h00);
      rd(2'd0, v); chk("R10 control after reset", v, 8'h00);
      chk("R10 outputs after reset",
          {flash_ce, flash_cle, flash_ale, eng_en, eng_clr, eng_go, busy}, 0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][11:10] == 2'd0) wr(VEC[i][9:8], VEC[i][7:0]);
         else begin
            rd(VEC[i][9:8], v);
            chk($sformatf("R1 R4 R8 R9 R10 table entry %0d", i), v, VEC[i][7:0]);
         end
      end

      // R1 pins follow control bits
      wr(2'd0, 8'h3C);
      chk("R1 pins 3C", {flash_ce, flash_cle, flash_ale}, 4'b1111);
      wr(2'd0, 8'h14);
      chk("R1 pins 14", {flash_ce, flash_cle, flash_ale}, 4'b0110);

      // R2 ECC reset gating
      wr(2'd0, 8'h02); chk("R2 reset ignored while disabled", eng_clr, 1'b0);
      wr(2'd0, 8'h01); chk("R2 enable only, no pulse", eng_clr, 1'b0);
      wr(2'd0, 8'h03); chk("R2 reset while enabled", eng_clr, 1'b1);
      idle();          chk("R2 reset pulse one cycle", eng_clr, 1'b0);

      // R3 write gating
      wr(2'd0, 8'h01);
      wr(2'd2, 8'hA5); chk("R3 write blocked", {p_we, p_valid}, 2'b00);
      wr(2'd0, 8'h41);
      wr(2'd2, 8'h5A);
      chk("R3 write strobe", {p_we, p_dout}, {1'b1, 8'h5A});
      chk("R5 write forwarded", {p_valid, p_byte, p_chk}, {1'b1, 8'h5A, 1'b0});

      // R5 read forwarding
      flash_din = 8'hC3;
      rd(2'd2, v);
      chk("R5 read data", {p_re, v}, {1'b1, 8'hC3});
      chk("R5 read forwarded", {p_valid, p_byte, p_chk}, {1'b1, 8'hC3, 1'b0});
      wr(2'd0, 8'h40);
      rd(2'd2, v); chk("R5 no forward when disabled", {p_re, p_valid}, 2'b10);

      // R6 / R7 lockout after check-byte reads
      wr(2'd1, 8'h03);
      wr(2'd0, 8'h81);
      flash_din = 8'h11;
      for (int k = 0; k < 3; k++) begin
         rd(2'd2, v);
         chk("R6 not busy before last check byte", busy, 1'b0);
      end
      rd(2'd2, v);
      chk("R5 check byte qualifier", {p_re, p_chk}, 2'b11);
      chk("R6 busy after last check byte", busy, 1'b1);
      rd(2'd2, v); chk("R7 read refused", p_re, 1'b0);
      rd(2'd3, v); chk("R7 busy and violation", v[1:0], 2'b11);
      wr(2'd1, 8'h07); chk("R7 start refused", eng_go, 1'b0);
      repeat (16) @(posedge clk);
      #1 chk("R6 still busy at cycle 20", busy, 1'b1);
      idle(); chk("R6 released after 20", busy, 1'b0);
      wr(2'd3, 8'h02);
      rd(2'd3, v); chk("R7 violation cleared", v, 8'h00);

      // R9 launch and done
      wr(2'd1, 8'h07); chk("R9 launch pulse", eng_go, 1'b1);
      idle();          chk("R9 pulse single", eng_go, 1'b0);
      rd(2'd3, v);     chk("R9 done clear before engine", v, 8'h00);
      eng_done = 1'b1; idle(); eng_done = 1'b0;
      rd(2'd3, v);     chk("R9 done set", v, 8'h04);
      wr(2'd1, 8'h07);
      rd(2'd3, v);     chk("R9 launch clears done", v, 8'h00);
      eng_done = 1'b1;
      wr(2'd1, 8'h07); chk("R9 launch in race", eng_go, 1'b1);
      eng_done = 1'b0;
      rd(2'd3, v);     chk("R9 done wins same cycle", v, 8'h04);
      wr(2'd1, 8'h04);
      chk("R9 no launch in Hamming", eng_go, 1'b0);
      chk("R4 Hamming forces qualifiers", {eng_is_chk, eng_decode}, 2'b00);

      fin = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule